// File: doc/BRIEF.md
# Multi-hart machine timer

This block holds one free-running 64-bit time counter shared by several harts, plus a private 64-bit deadline register per hart. Each hart gets a level-sensitive timer interrupt that is high whenever its deadline has been reached, meaning the deadline is less than or equal to the counter in an unsigned 64-bit comparison. The counter advances by one on every clock in which the timebase tick input is high. Any write, whether to a deadline or to the counter itself, re-evaluates every affected interrupt in the same clock edge.

Software reaches the registers over a small single-cycle register bus. Both 32-bit and 64-bit accesses are accepted, laid out little-endian. Deadline slots start at a configurable base and are 8 bytes apart. Slot i belongs to hart i and drives `irq_o[i]`. The counter occupies one 8-byte slot at a second configurable base. Both bases must be 8-byte aligned, and the hart count may not exceed a configured maximum. This limit is checked at elaboration.

Top module: `mtmr_top`

## Requirements
- R1: After reset the counter reads zero, every deadline reads all-ones (0xFFFF_FFFF_FFFF_FFFF), and every interrupt output is low.
- R2: The deadline of hart i sits at CMP_BASE + 8*i. Its low word is at byte offset 0 and its high word at byte offset 4. It drives only irq_o[i], and a write to one slot leaves all other slots unchanged.
- R3: The counter sits at TIME_BASE. Its low word is at offset 0 and its high word at offset 4.
- R4: For every register, the write width decides which bits change:
  - A 32-bit write (bus_wide_i=0) at offset 0 replaces bits 31:0 with wdata[31:0] and keeps bits 63:32.
  - A 32-bit write at offset 4 replaces bits 63:32 with wdata[31:0] and keeps bits 31:0.
  - A 64-bit write (bus_wide_i=1) at offset 0 replaces all 64 bits with wdata[63:0].
- R5: A 64-bit write at offset 4 of any register changes nothing.
- R6: Reads return data combinationally in the cycle of the request:
  - A 32-bit read at offset 0 returns {32'h0, bits 31:0}.
  - A 64-bit read at offset 0 returns all 64 bits.
  - A read of either width at offset 4 returns {32'h0, bits 63:32}.
  - bus_rdata_o is zero when no read is requested.
- R7: An access whose address bits 2:0 are neither 0 nor 4, or whose address lies outside both regions, reads as zero and its write changes no register.
- R8: The counter increases by one on each rising clock edge with tick_i high, and wraps from all-ones to zero.
- R9: A counter write in a cycle with tick_i high takes the written value, with no increment.
- R10: From the clock edge that updates the registers, irq_o[i] equals (deadline[i] <= counter) as an unsigned comparison. This holds after deadline writes, counter writes and tick increments alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| tick_i | input | 1 | Timebase tick, one-cycle pulse per count |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr_i | input | ADDR_W (16) | Byte address |
| bus_wdata_i | input | 64 | Write data; a 32-bit access uses bits 31:0 |
| bus_rdata_o | output | 64 | Read data, valid in the request cycle |
| irq_o | output | NUM_HARTS (4) | Per-hart timer interrupt level |

## Verification
The checker assumes that tick_i and every bus signal are stable around each rising edge. It also assumes that a request lasts exactly the one cycle in which bus_valid_i is high, and that the two regions do not overlap. The bench drives every input at the falling edge and holds each request for a single rising edge. It uses the default bases, which are disjoint and 8-byte aligned, so every write lands in at most one register. Tick pulses are issued only inside bus operations, so the bench model knows whether each edge carried a write, a tick, or both.

// File: rtl/mtmr_pkg.sv
`timescale 1ns/1ps
package mtmr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_W  = 64;

  typedef logic [REG_W-1:0] reg64_t;

  // decoded view of one bus request
  typedef struct packed {
    logic sel_cmp;   // address falls in the deadline region
    logic sel_time;  // address falls in the counter slot
    logic at_lo;     // byte offset 0 within the slot
    logic at_hi;     // byte offset 4 within the slot
    logic we_lo;     // write updates bits 31:0
    logic we_hi;     // write updates bits 63:32
    logic rd;        // read of a decoded register
  } mtmr_acc_t;
endpackage

// File: rtl/mtmr_decode.sv
`timescale 1ns/1ps
module mtmr_decode
  import mtmr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned CMP_BASE  = 32'h0000_1000,
  parameter int unsigned TIME_BASE = 32'h0000_7FF8,
  parameter int unsigned SLOT_W    = 2
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mtmr_acc_t         acc_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [31:0] CB      = CMP_BASE;
  localparam logic [31:0] TB      = TIME_BASE;
  localparam logic [31:0] CMP_END = CB + 32'(NUM_HARTS) * 32'd8;

  logic [31:0] addr_ext;
  logic        in_cmp;
  logic        in_time;
  logic        off_lo;
  logic        off_hi;
  logic        wr;

  always_comb begin
    addr_ext = 32'(addr_i);
    in_cmp   = (addr_ext >= CB) && (addr_ext < CMP_END);
    in_time  = (addr_ext[31:3] == TB[31:3]);
    off_lo   = (addr_ext[2:0] == 3'd0);
    off_hi   = (addr_ext[2:0] == 3'd4);
    wr       = valid_i & write_i & (in_cmp | in_time);
    // bases are 8-byte aligned, so the low three bits never borrow
    slot_o   = addr_ext[SLOT_W+2:3] - CB[SLOT_W+2:3];

    acc_o.sel_cmp  = in_cmp;
    acc_o.sel_time = in_time;
    acc_o.at_lo    = off_lo;
    acc_o.at_hi    = off_hi;
    acc_o.we_lo    = wr & off_lo;
    acc_o.we_hi    = wr & ((off_lo & wide_i) | (off_hi & ~wide_i));
    acc_o.rd       = valid_i & ~write_i & (in_cmp | in_time);
  end
endmodule

// File: rtl/mtmr_counter.sv
`timescale 1ns/1ps
module mtmr_counter
  import mtmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [WORD_W-1:0] wlo_i,
  input  logic [WORD_W-1:0] whi_i,
  output reg64_t            time_q_o,
  output reg64_t            time_d_o
);
  reg64_t time_q;
  reg64_t time_d;
  logic   time_en;

  // software write has priority over the tick increment
  always_comb begin
    time_en = we_lo_i | we_hi_i | tick_i;
    if (we_lo_i || we_hi_i) begin
      time_d = { (we_hi_i ? whi_i : time_q[REG_W-1:WORD_W]),
                 (we_lo_i ? wlo_i : time_q[WORD_W-1:0]) };
    end else if (tick_i) begin
      time_d = time_q + reg64_t'(1);
    end else begin
      time_d = time_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
    end else if (time_en) begin
      time_q <= time_d;
    end
  end

  assign time_q_o = time_q;
  assign time_d_o = time_d;
endmodule

// File: rtl/mtmr_cmp_bank.sv
`timescale 1ns/1ps
module mtmr_cmp_bank
  import mtmr_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned SLOT_W    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic                       we_lo_i,
  input  logic                       we_hi_i,
  input  logic [WORD_W-1:0]          wlo_i,
  input  logic [WORD_W-1:0]          whi_i,
  input  reg64_t                     time_d_i,
  output logic [NUM_HARTS*REG_W-1:0] cmp_flat_o,
  output logic [NUM_HARTS-1:0]       irq_o
);
  logic [NUM_HARTS-1:0] irq_d;
  logic [NUM_HARTS-1:0] irq_q;

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_slot
    reg64_t cmp_q;
    reg64_t cmp_d;
    logic   hit;
    logic   wl;
    logic   wh;

    always_comb begin
      hit   = sel_i & (slot_i == SLOT_W'(i));
      wl    = hit & we_lo_i;
      wh    = hit & we_hi_i;
      cmp_d = { (wh ? whi_i : cmp_q[REG_W-1:WORD_W]),
                (wl ? wlo_i : cmp_q[WORD_W-1:0]) };
      // compare against next-state values so a write acts in its own edge
      irq_d[i] = (cmp_d <= time_d_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q <= '1;
      end else if (wl || wh) begin
        cmp_q <= cmp_d;
      end
    end

    assign cmp_flat_o[i*REG_W +: REG_W] = cmp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mtmr_top.sv
`timescale 1ns/1ps
module mtmr_top
  import mtmr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned MAX_HARTS = 16,
  parameter int unsigned CMP_BASE  = 32'h0000_1000,
  parameter int unsigned TIME_BASE = 32'h0000_7FF8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic                 bus_wide_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [63:0]          bus_wdata_i,
  output logic [63:0]          bus_rdata_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int unsigned SLOT_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  if (NUM_HARTS > MAX_HARTS || NUM_HARTS == 0) begin : g_bad_cfg
    $error("mtmr_top: NUM_HARTS out of range");
  end

  mtmr_acc_t                  acc;
  logic [SLOT_W-1:0]          slot;
  logic [WORD_W-1:0]          wlo;
  logic [WORD_W-1:0]          whi;
  reg64_t                     time_q;
  reg64_t                     time_d;
  logic [NUM_HARTS*REG_W-1:0] cmp_flat;
  reg64_t                     rd_word;

  // a 32-bit high-word write carries its data in the low lane
  assign wlo = bus_wdata_i[WORD_W-1:0];
  assign whi = bus_wide_i ? bus_wdata_i[REG_W-1:WORD_W] : bus_wdata_i[WORD_W-1:0];

  mtmr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_HARTS(NUM_HARTS),
    .CMP_BASE (CMP_BASE),
    .TIME_BASE(TIME_BASE),
    .SLOT_W   (SLOT_W)
  ) u_dec (
    .valid_i(bus_valid_i),
    .write_i(bus_write_i),
    .wide_i (bus_wide_i),
    .addr_i (bus_addr_i),
    .acc_o  (acc),
    .slot_o (slot)
  );

  mtmr_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .we_lo_i (acc.we_lo & acc.sel_time),
    .we_hi_i (acc.we_hi & acc.sel_time),
    .wlo_i   (wlo),
    .whi_i   (whi),
    .time_q_o(time_q),
    .time_d_o(time_d)
  );

  mtmr_cmp_bank #(
    .NUM_HARTS(NUM_HARTS),
    .SLOT_W   (SLOT_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (acc.sel_cmp),
    .slot_i    (slot),
    .we_lo_i   (acc.we_lo),
    .we_hi_i   (acc.we_hi),
    .wlo_i     (wlo),
    .whi_i     (whi),
    .time_d_i  (time_d),
    .cmp_flat_o(cmp_flat),
    .irq_o     (irq_o)
  );

  // combinational read path
  always_comb begin
    rd_word = '0;
    if (acc.sel_time) rd_word = time_q;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (acc.sel_cmp && slot == SLOT_W'(i)) rd_word = cmp_flat[i*REG_W +: REG_W];
    end
    bus_rdata_o = '0;
    if (acc.rd) begin
      if (acc.at_lo) begin
        bus_rdata_o = bus_wide_i ? rd_word : {32'h0, rd_word[WORD_W-1:0]};
      end else if (acc.at_hi) begin
        bus_rdata_o = {32'h0, rd_word[REG_W-1:WORD_W]};
      end
    end
  end
endmodule

// File: rtl/mtmr_chk.sv
`timescale 1ns/1ps
module mtmr_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned TIME_BASE = 32'h0000_7FF8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    bus_valid_i,
  input logic                    bus_write_i,
  input logic                    bus_wide_i,
  input logic [ADDR_W-1:0]       bus_addr_i,
  input logic [63:0]             bus_wdata_i,
  input logic [NUM_HARTS-1:0]    irq_o,
  input logic [63:0]             time_q,
  input logic [NUM_HARTS*64-1:0] cmp_flat
);
  localparam logic [31:0] TB = TIME_BASE;

  logic [31:0] a32;
  logic        wr;
  logic        in_time;
  logic        time_wr;
  logic        time_lo_narrow;
  logic        time_lo_wide;
  logic        wide_hi_wr;
  logic        misaligned_wr;

  always_comb begin
    a32            = 32'(bus_addr_i);
    wr             = bus_valid_i & bus_write_i;
    in_time        = (a32[31:3] == TB[31:3]);
    time_lo_narrow = wr & in_time & (a32[2:0] == 3'd0) & ~bus_wide_i;
    time_lo_wide   = wr & in_time & (a32[2:0] == 3'd0) &  bus_wide_i;
    time_wr        = time_lo_narrow | time_lo_wide |
                     (wr & in_time & (a32[2:0] == 3'd4) & ~bus_wide_i);
    wide_hi_wr     = wr & bus_wide_i & (a32[2:0] == 3'd4);
    misaligned_wr  = wr & (a32[1:0] != 2'd0);
  end

  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (time_q == 64'h0 && irq_o == '0));

  assert_narrow_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_lo_narrow |=> (time_q == {$past(time_q[63:32]), $past(bus_wdata_i[31:0])}));

  assert_wide_hi_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_hi_wr |=> $stable(cmp_flat));

  assert_bad_offset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_wr |=> $stable(cmp_flat));

  assert_tick_incr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !time_wr) |=> (time_q == $past(time_q) + 64'd1));

  assert_wr_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_lo_wide |=> (time_q == $past(bus_wdata_i)));

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_irq
    assert_irq_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] == (cmp_flat[i*64 +: 64] <= time_q));
  end
endmodule

bind mtmr_top mtmr_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_HARTS(NUM_HARTS),
  .TIME_BASE(TIME_BASE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i),
  .bus_wide_i (bus_wide_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .time_q     (time_q),
  .cmp_flat   (cmp_flat)
);

// File: tb/sim_mtmr_top.sv
`timescale 1ns/1ps
module sim_mtmr_top;
  localparam int          NH = 4;
  localparam logic [15:0] CB = 16'h1000;
  localparam logic [15:0] TB = 16'h7FF8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        valid;
  logic        write;
  logic        wide;
  logic [15:0] addr;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic [NH-1:0] irq;

  always #2.5 clk = ~clk;

  mtmr_top #(
    .ADDR_W   (16),
    .NUM_HARTS(NH),
    .MAX_HARTS(16),
    .CMP_BASE (32'(CB)),
    .TIME_BASE(32'(TB))
  ) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .bus_valid_i(valid),
    .bus_write_i(write),
    .bus_wide_i (wide),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  logic [63:0] cmp_m [NH];
  logic [63:0] time_m;
  int tests = 0;
  int fails = 0;
  bit done  = 0;

  function automatic logic [63:0] wr_model(logic [63:0] old, logic [2:0] off,
                                           logic w, logic [63:0] d);
    if (off == 3'd0) return w ? d : {old[63:32], d[31:0]};
    if (off == 3'd4 && !w) return {d[31:0], old[31:0]};
    return old;
  endfunction

  function automatic logic [63:0] rd_model(logic [63:0] v, logic [2:0] off, logic w);
    if (off == 3'd0) return w ? v : {32'h0, v[31:0]};
    if (off == 3'd4) return {32'h0, v[63:32]};
    return 64'h0;
  endfunction

  function automatic bit in_cmp(logic [15:0] a);
    return (a >= CB) && (int'(a) < int'(CB) + NH*8);
  endfunction

  function automatic logic [NH-1:0] irq_exp();
    logic [NH-1:0] r;
    for (int i = 0; i < NH; i++) r[i] = (cmp_m[i] <= time_m);
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus operation spanning exactly one rising edge
  task automatic op(bit wr, logic [15:0] a, bit w, logic [63:0] d, bit tk,
                    output logic [63:0] rd);
    bit twr;
    @(negedge clk);
    valid = 1'b1; write = wr; addr = a; wide = w; wdata = d; tick = tk;
    #1 rd = rdata;
    @(posedge clk);
    twr = 0;
    if (wr) begin
      if (in_cmp(a)) begin
        int idx = (int'(a) - int'(CB)) >> 3;
        cmp_m[idx] = wr_model(cmp_m[idx], a[2:0], w, d);
      end else if (a[15:3] == TB[15:3]) begin
        twr = (a[2:0] == 3'd0) || (a[2:0] == 3'd4 && !w);
        time_m = wr_model(time_m, a[2:0], w, d);
      end
    end
    if (!twr && tk) time_m = time_m + 64'd1;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; tick = 1'b0;
    chk("R10 irq level", 64'(irq), 64'(irq_exp()));
  endtask

  task automatic rdchk(string tag, logic [15:0] a, bit w);
    logic [63:0] rd;
    logic [63:0] exp;
    exp = 64'h0;
    if (in_cmp(a)) exp = rd_model(cmp_m[(int'(a) - int'(CB)) >> 3], a[2:0], w);
    else if (a[15:3] == TB[15:3]) exp = rd_model(time_m, a[2:0], w);
    op(0, a, w, 64'h0, 0, rd);
    chk(tag, rd, exp);
  endtask

  task automatic wr(logic [15:0] a, bit w, logic [63:0] d, bit tk);
    logic [63:0] rd;
    op(1, a, w, d, tk, rd);
  endtask

  task automatic full_readback(string tag);
    for (int s = 0; s < NH; s++) rdchk(tag, CB + 16'(s*8), 1);
    rdchk(tag, TB, 1);
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; valid = 0; write = 0; wide = 0; addr = '0; wdata = '0;
    time_m = 64'h0;
    for (int i = 0; i < NH; i++) cmp_m[i] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", 64'(irq), 64'h0);
    chk("R6 idle rdata zero", rdata, 64'h0);
    full_readback("R1 reset readback");

    // R2 R4 R5 R6 R7: sweep every offset of every deadline slot, both widths
    for (int s = 0; s < NH; s++) begin
      for (int off = 0; off < 8; off++) begin
        for (int w = 0; w < 2; w++) begin
          logic [63:0] d;
          logic [15:0] a;
          a = CB + 16'(s*8 + off);
          d = {8'hC0 + 8'(s), 8'(off), 8'(w), 8'h5A,
               32'h0BAD_0000 | 32'(s << 12) | 32'(off << 4) | 32'(w)};
          if (s == 2 && off == 0 && w == 1) d = 64'h0;
          wr(a, w[0], d, 0);
          rdchk("R6 read at write offset", a, w[0]);
          rdchk("R4 R5 low word", CB + 16'(s*8), 0);
          rdchk("R4 R5 high word", CB + 16'(s*8 + 4), 0);
          full_readback("R2 slot isolation");
        end
      end
    end

    // deadlines for the counter sweep
    wr(CB + 16'd0,  1, 64'h0000_0000_0000_0010, 0);
    wr(CB + 16'd8,  1, 64'h0000_0001_0000_0000, 0);
    wr(CB + 16'd16, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    wr(CB + 16'd24, 1, 64'h8000_0000_0000_0000, 0);

    // R3 R4 R5 R7 R10: sweep counter offsets, both widths
    for (int off = 0; off < 8; off++) begin
      for (int w = 0; w < 2; w++) begin
        logic [63:0] d;
        d = w ? {32'(off >> 1) | 32'(off << 28), 32'h0000_000C + 32'(off) * 32'h8}
              : {32'h0, 32'(off) * 32'h4000_0000 + 32'h11};
        wr(TB + 16'(off), w[0], d, 0);
        rdchk("R3 counter low", TB, 0);
        rdchk("R3 counter high", TB + 16'd4, 1);
        rdchk("R6 counter wide", TB, 1);
        rdchk("R7 counter odd offset", TB + 16'(off), w[0]);
      end
    end

    // R7 undecoded addresses
    wr(CB + 16'(NH*8), 1, 64'h1234_5678_9ABC_DEF0, 0);
    wr(16'h4000, 1, 64'h0, 0);
    wr(16'h0FF8, 0, 64'h0, 0);
    rdchk("R7 read past last slot", CB + 16'(NH*8), 1);
    rdchk("R7 read unmapped", 16'h4000, 1);
    full_readback("R7 nothing changed");

    // R8 R10 increment across the 32-bit boundary raises irq without a write
    wr(CB + 16'd8, 1, 64'h0000_0001_0000_0000, 0);
    wr(TB, 1, 64'h0000_0000_FFFF_FFFE, 0);
    chk("R10 not yet due", 64'(irq[1]), 64'h0);
    wr(16'h4000, 0, 64'h0, 1);
    rdchk("R8 after first tick", TB, 1);
    chk("R10 one before deadline", 64'(irq[1]), 64'h0);
    wr(16'h4000, 0, 64'h0, 1);
    rdchk("R8 carry into high word", TB, 1);
    chk("R10 raised by tick", 64'(irq[1]), 64'h1);

    // R8 wrap from all-ones to zero
    wr(CB + 16'd24, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    wr(TB, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0);
    chk("R10 max deadline pending", 64'(irq[3]), 64'h0);
    wr(16'h4000, 0, 64'h0, 1);
    chk("R10 max deadline reached", 64'(irq[3]), 64'h1);
    wr(16'h4000, 0, 64'h0, 1);
    rdchk("R8 wrap to zero", TB, 1);
    chk("R10 cleared by wrap", 64'(irq[3]), 64'h0);

    // R9 write beats tick
    wr(TB, 1, 64'h0000_0000_0000_0055, 1);
    rdchk("R9 wide write with tick", TB, 1);
    wr(TB + 16'd4, 0, 64'h0000_0000_0000_0007, 1);
    rdchk("R9 high write with tick", TB, 1);
    wr(TB + 16'd3, 0, 64'h0, 1);
    rdchk("R8 tick with ignored write", TB, 1);

    // R10 deadline in the future clears, in the past raises
    wr(CB, 1, 64'h0, 0);
    chk("R10 past deadline", 64'(irq[0]), 64'h1);
    wr(CB, 1, time_m + 64'd100, 0);
    chk("R10 future deadline", 64'(irq[0]), 64'h0);
    chk("R6 idle rdata zero end", rdata, 64'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule